// File: doc/BRIEF.md
# Doorbell-Driven Command Queue Engine

This block is the device-side engine for one circular submission ring and the completion ring paired with it. Both rings live in host memory, which the engine reaches through a simple request/response memory port. The host writes commands into the submission ring and then writes a new tail index to a submission doorbell input. The engine reads every newly covered 64-byte command in four 16-byte beats. It passes each command to a small execution stub. It then writes a 16-byte completion record into the completion ring and raises an interrupt.

The host reads completion records by watching their phase bit. It returns completion slots by writing a new head index to a completion doorbell input. One doorbell write may cover many entries. When the completion ring has no free slot, the engine holds the finished command until the host frees one. A doorbell write that carries an index outside its ring is dropped, and the engine flags it.

Top module: `cmdq_engine`

## Requirements
- R1: No memory read is issued while the submission head equals the doorbell tail. Placing commands in memory without a doorbell write causes no fetch.
- R2: A single submission doorbell write that advances the tail by N entries causes all N commands to be fetched and completed, in ring order.
- R3: Command beat b of submission slot i is read at SQ_BASE + 64*i + 16*b. The completion for slot j is written at CQ_BASE + 16*j. Both indices wrap to 0 after depth-1.
- R4: Each command is handled in this order: four read beats, then the execution delay, then exactly one completion write. The interrupt rises one cycle after that write is acknowledged, and memory requests are single-cycle pulses.
- R5: Completion bits [111:96] return the command identifier taken from command bits [31:16]. Bits [95:80] carry QUEUE_ID. Bits [79:64] carry the submission head index after the command was consumed.
- R6: Completion bit 112 is the phase bit. It is 1 during the first pass through the completion ring and inverts each time the completion tail wraps to index 0.
- R7: The ring is full when (tail+1) mod CQ_DEPTH equals head, so at most CQ_DEPTH-1 completions are outstanding. No completion write is issued while the ring is full, and posting resumes after a head doorbell frees a slot.
- R8: A doorbell write with an index >= its ring depth leaves that ring pointer unchanged. The cycle after the write, dbErr is 1 for one cycle. A write with a valid index leaves dbErr at 0.
- R9: irq is 0 after reset. It is 1 while the completion tail differs from the host's completion head, and it falls once a head doorbell catches up.
- R10: Completion bits [127:113] hold status: 1 when opcode bit 7 (command bit 7) is set, otherwise 0. Bits [31:0] hold the XOR of all sixteen 32-bit words of the command. Bits [63:32] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| sqDbWr | input | 1 | Submission tail doorbell write strobe |
| sqDbValue | input | 16 | New submission tail index |
| cqDbWr | input | 1 | Completion head doorbell write strobe |
| cqDbValue | input | 16 | New completion head index |
| memReq | output | 1 | Single-cycle memory request |
| memWe | output | 1 | Request is a write (completion post) |
| memAddr | output | ADDR_W | Byte address of the 16-byte beat |
| memWdata | output | 128 | Completion record |
| memRspValid | input | 1 | Response for the outstanding request |
| memRdata | input | 128 | Read beat data |
| irq | output | 1 | Completion interrupt (level) |
| dbErr | output | 1 | Out-of-range doorbell pulse |

## Verification
The assertions rely on three conditions. The host never moves the completion head past entries the engine has posted. The host never fills the submission ring beyond depth-1 outstanding entries. The memory returns exactly one response per request and never an unsolicited one. The bench keeps to all three. Its host model computes every doorbell value from its own ring pointers, and it keeps each batch to at most SQ_DEPTH-1 commands. It rings the completion head only over records whose phase bit it has already seen. Its memory model answers each request once, after a random delay of one to three cycles. Out-of-range doorbell values are the only stimulus outside normal host behaviour, and these fall under R8.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int IDX_W      = 16;
  localparam int BEAT_BITS  = 128;
  localparam int BEAT_BYTES = BEAT_BITS / 8;
  localparam int CMD_BYTES  = 64;
  localparam int CPL_BYTES  = 16;
  localparam int BEATS      = CMD_BYTES / BEAT_BYTES;

  typedef struct packed {
    logic fetchReq;
    logic takeBeat;
    logic consumeSq;
    logic postReq;
    logic advanceCq;
  } cmdq_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_FWAIT, ST_EXEC, ST_POST, ST_PWAIT
  } cmdq_state_t;
endpackage

// File: rtl/cmdq_datapath.sv
module cmdq_datapath
  import cmdq_pkg::*;
#(
  parameter int                SQ_DEPTH = 8,
  parameter int                CQ_DEPTH = 4,
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] SQ_BASE  = 'h1000,
  parameter logic [ADDR_W-1:0] CQ_BASE  = 'h2000,
  parameter logic [15:0]       QUEUE_ID = 16'h0003
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cmdq_strobe_t         strobe,
  input  logic [BEAT_BITS-1:0] memRdata,
  input  logic                 sqDbWr,
  input  logic [IDX_W-1:0]     sqDbValue,
  input  logic                 cqDbWr,
  input  logic [IDX_W-1:0]     cqDbValue,
  output logic                 sqPending,
  output logic                 cqFull,
  output logic                 lastBeat,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [BEAT_BITS-1:0] memWdata,
  output logic                 irq,
  output logic                 dbErr
);
  localparam int BEAT_W     = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int CMD_SHIFT  = $clog2(CMD_BYTES);
  localparam int CPL_SHIFT  = $clog2(CPL_BYTES);
  localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);
  localparam int WORDS      = BEAT_BITS / 32;
  localparam logic [IDX_W-1:0] SQ_LAST = IDX_W'(SQ_DEPTH - 1);
  localparam logic [IDX_W-1:0] CQ_LAST = IDX_W'(CQ_DEPTH - 1);
  localparam logic [IDX_W:0]   SQ_LIM  = (IDX_W + 1)'(SQ_DEPTH);
  localparam logic [IDX_W:0]   CQ_LIM  = (IDX_W + 1)'(CQ_DEPTH);

  logic [IDX_W-1:0]  sqHead, sqTail, cqHead, cqTail;
  logic              phase;
  logic [BEAT_W-1:0] beatIdx;
  logic [7:0]        cmdOpcode;
  logic [15:0]       cmdCid;
  logic [31:0]       foldAcc, beatFold;
  logic              sqOk, cqOk;
  logic [14:0]       statusCode;
  logic [ADDR_W-1:0] fetchAddr, postAddr;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] idx,
                                            input logic [IDX_W-1:0] last);
    return (idx == last) ? '0 : idx + 1'b1;
  endfunction

  function automatic logic [31:0] foldBeat(input logic [BEAT_BITS-1:0] b);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < WORDS; i++) r ^= b[32*i +: 32];
    return r;
  endfunction

  assign sqOk      = {1'b0, sqDbValue} < SQ_LIM;
  assign cqOk      = {1'b0, cqDbValue} < CQ_LIM;
  assign sqPending = (sqHead != sqTail);
  assign cqFull    = (bump(cqTail, CQ_LAST) == cqHead);
  assign lastBeat  = (beatIdx == BEAT_W'(BEATS - 1));
  assign irq       = (cqTail != cqHead);
  assign beatFold  = foldBeat(memRdata);

  // Doorbell registers: each pointer written by a single agent
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqTail <= '0;
      cqHead <= '0;
      dbErr  <= 1'b0;
    end else begin
      if (sqDbWr && sqOk) sqTail <= sqDbValue;
      if (cqDbWr && cqOk) cqHead <= cqDbValue;
      dbErr <= (sqDbWr && !sqOk) || (cqDbWr && !cqOk);
    end
  end

  // Engine-owned pointers and the command latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqHead    <= '0;
      cqTail    <= '0;
      phase     <= 1'b1;
      beatIdx   <= '0;
      cmdOpcode <= '0;
      cmdCid    <= '0;
      foldAcc   <= '0;
    end else begin
      if (strobe.takeBeat) begin
        beatIdx <= lastBeat ? '0 : beatIdx + 1'b1;
        foldAcc <= ((beatIdx == '0) ? 32'h0 : foldAcc) ^ beatFold;
        if (beatIdx == '0) begin
          cmdOpcode <= memRdata[7:0];
          cmdCid    <= memRdata[31:16];
        end
      end
      if (strobe.consumeSq) sqHead <= bump(sqHead, SQ_LAST);
      if (strobe.advanceCq) begin
        cqTail <= bump(cqTail, CQ_LAST);
        if (cqTail == CQ_LAST) phase <= ~phase;
      end
    end
  end

  // Execution stub result and completion record
  assign statusCode = {14'b0, cmdOpcode[7]};
  assign memWdata   = {statusCode, phase, cmdCid, QUEUE_ID, sqHead, 32'h0, foldAcc};

  assign fetchAddr = SQ_BASE + (ADDR_W'(sqHead) << CMD_SHIFT)
                             + (ADDR_W'(beatIdx) << BEAT_SHIFT);
  assign postAddr  = CQ_BASE + (ADDR_W'(cqTail) << CPL_SHIFT);
  assign memAddr   = strobe.postReq ? postAddr : fetchAddr;

  p_fetch_covered_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fetchReq |-> sqPending);
  p_no_post_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.postReq |-> !cqFull);
  p_phase_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advanceCq && cqTail == CQ_LAST) |=> (phase != $past(phase)));
  p_bad_sq_db_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sqDbWr && !sqOk) |=> ($stable(sqTail) && dbErr));
  p_bad_cq_db_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cqDbWr && !cqOk) |=> ($stable(cqHead) && dbErr));
endmodule

// File: rtl/cmdq_control.sv
module cmdq_control
  import cmdq_pkg::*;
#(
  parameter int EXEC_CYCLES = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sqPending,
  input  logic         cqFull,
  input  logic         lastBeat,
  input  logic         memRspValid,
  output cmdq_strobe_t strobe
);
  localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

  cmdq_state_t state, nextState;
  logic [CNT_W-1:0] execCnt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE:  if (sqPending) nextState = ST_FETCH;
      ST_FETCH: begin
        strobe.fetchReq = 1'b1;
        nextState       = ST_FWAIT;
      end
      ST_FWAIT: if (memRspValid) begin
        strobe.takeBeat = 1'b1;
        if (lastBeat) begin
          strobe.consumeSq = 1'b1;
          nextState        = ST_EXEC;
        end else begin
          nextState = ST_FETCH;
        end
      end
      ST_EXEC:  if (execCnt == '0) nextState = ST_POST;
      ST_POST:  if (!cqFull) begin
        strobe.postReq = 1'b1;
        nextState      = ST_PWAIT;
      end
      ST_PWAIT: if (memRspValid) begin
        strobe.advanceCq = 1'b1;
        nextState        = ST_IDLE;
      end
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      execCnt <= '0;
    end else begin
      state <= nextState;
      if (strobe.consumeSq)                       execCnt <= CNT_W'(EXEC_CYCLES - 1);
      else if (state == ST_EXEC && execCnt != '0) execCnt <= execCnt - 1'b1;
    end
  end

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fetchReq || strobe.postReq) |=> !(strobe.fetchReq || strobe.postReq));
  p_post_after_fetch_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.postReq |-> !sqPending || state == ST_POST);
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int                SQ_DEPTH    = 8,
  parameter int                CQ_DEPTH    = 4,
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] SQ_BASE     = 'h1000,
  parameter logic [ADDR_W-1:0] CQ_BASE     = 'h2000,
  parameter logic [15:0]       QUEUE_ID    = 16'h0003,
  parameter int                EXEC_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sqDbWr,
  input  logic [15:0]       sqDbValue,
  input  logic              cqDbWr,
  input  logic [15:0]       cqDbValue,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [127:0]      memWdata,
  input  logic              memRspValid,
  input  logic [127:0]      memRdata,
  output logic              irq,
  output logic              dbErr
);
  cmdq_strobe_t strobe;
  logic sqPending, cqFull, lastBeat;

  cmdq_control #(.EXEC_CYCLES(EXEC_CYCLES)) i_control (
    .clk, .rstN, .sqPending, .cqFull, .lastBeat, .memRspValid, .strobe
  );

  cmdq_datapath #(
    .SQ_DEPTH(SQ_DEPTH), .CQ_DEPTH(CQ_DEPTH), .ADDR_W(ADDR_W),
    .SQ_BASE(SQ_BASE), .CQ_BASE(CQ_BASE), .QUEUE_ID(QUEUE_ID)
  ) i_datapath (
    .clk, .rstN, .strobe, .memRdata, .sqDbWr, .sqDbValue, .cqDbWr, .cqDbValue,
    .sqPending, .cqFull, .lastBeat, .memAddr, .memWdata, .irq, .dbErr
  );

  assign memReq = strobe.fetchReq | strobe.postReq;
  assign memWe  = strobe.postReq;

  p_irq_after_post_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(strobe.advanceCq));
endmodule

// File: tb/test_cmdq_engine.sv
`timescale 1ns/1ps
module test_cmdq_engine;
  localparam int          SQD = 8;
  localparam int          CQD = 4;
  localparam logic [31:0] SQB = 32'h1000;
  localparam logic [31:0] CQB = 32'h2000;
  localparam logic [15:0] QID = 16'h0003;

  logic clk = 1'b0, rstN = 1'b0;
  logic sqDbWr = 1'b0, cqDbWr = 1'b0;
  logic [15:0] sqDbValue = '0, cqDbValue = '0;
  logic memReq, memWe, memRspValid = 1'b0, irq, dbErr;
  logic [31:0]  memAddr;
  logic [127:0] memWdata, memRdata = '0;

  cmdq_engine #(.SQ_DEPTH(SQD), .CQ_DEPTH(CQD), .SQ_BASE(SQB), .CQ_BASE(CQB),
                .QUEUE_ID(QID), .EXEC_CYCLES(3)) i_cmdq_engine (
    .clk, .rstN, .sqDbWr, .sqDbValue, .cqDbWr, .cqDbValue, .memReq, .memWe,
    .memAddr, .memWdata, .memRspValid, .memRdata, .irq, .dbErr
  );

  always #2 clk = ~clk;

  logic [127:0] mem [0:1023];
  int testsRun = 0, testsFailed = 0;
  bit finished = 0;
  int cycle = 0, readCnt = 0, wrCnt = 0, totalCmds = 0;
  int fetchAddrBad = 0, cplAddrBad = 0, beatOrderBad = 0, irqOrderBad = 0;
  int monFetchIdx = 0, monBeat = 0, monCqIdx = 0, beatsSinceWr = 0, lastAckCycle = -10;
  bit prevIrq = 0;
  int pendCnt = 0;
  bit pendWe = 0;
  logic [31:0]  pendAddr = '0;
  logic [127:0] pendData = '0;

  function automatic int slotOf(logic [31:0] a);
    return int'((a >> 4) & 32'd1023);
  endfunction

  // Memory model and bus monitor, away from the active edge
  always @(negedge clk) begin
    cycle++;
    memRspValid = 1'b0;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        memRspValid = 1'b1;
        if (pendWe) begin
          mem[slotOf(pendAddr)] = pendData;
          lastAckCycle = cycle;
        end else begin
          memRdata = mem[slotOf(pendAddr)];
        end
      end
    end
    if (rstN && irq === 1'b1 && !prevIrq && (cycle - lastAckCycle != 1)) irqOrderBad++;
    prevIrq = rstN && (irq === 1'b1);
    if (rstN && memReq === 1'b1) begin
      pendCnt  = 1 + int'($urandom % 3);
      pendWe   = memWe;
      pendAddr = memAddr;
      pendData = memWdata;
      if (memWe) begin
        wrCnt++;
        if (memAddr != CQB + 32'(monCqIdx * 16)) cplAddrBad++;
        monCqIdx = (monCqIdx + 1) % CQD;
        if (beatsSinceWr != 4) beatOrderBad++;
        beatsSinceWr = 0;
      end else begin
        readCnt++;
        beatsSinceWr++;
        if (memAddr != SQB + 32'(monFetchIdx * 64 + monBeat * 16)) fetchAddrBad++;
        monBeat++;
        if (monBeat == 4) begin
          monBeat = 0;
          monFetchIdx = (monFetchIdx + 1) % SQD;
        end
      end
    end
  end

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  int hostSqTail = 0, hostCqRd = 0, hostCplSq = 0;
  bit expPhase = 1'b1;
  logic [7:0]  sqOp  [SQD];
  logic [15:0] sqCid [SQD];
  logic [31:0] sqRes [SQD];

  task automatic putCmd(logic [7:0] op, logic [15:0] cid);
    logic [127:0] w;
    logic [31:0] f;
    f = '0;
    for (int b = 0; b < 4; b++) begin
      w = {$urandom, $urandom, $urandom, $urandom};
      if (b == 0) w[31:0] = {cid, 8'($urandom), op};
      for (int d = 0; d < 4; d++) f ^= w[32*d +: 32];
      mem[slotOf(SQB) + hostSqTail * 4 + b] = w;
    end
    sqOp[hostSqTail]  = op;
    sqCid[hostSqTail] = cid;
    sqRes[hostSqTail] = f;
    hostSqTail = (hostSqTail + 1) % SQD;
    totalCmds++;
  endtask

  task automatic ringSq(int v, output bit err);
    @(negedge clk);
    sqDbWr = 1'b1; sqDbValue = 16'(v);
    @(negedge clk);
    sqDbWr = 1'b0;
    err = dbErr;
  endtask

  task automatic ringCq(int v, output bit err);
    @(negedge clk);
    cqDbWr = 1'b1; cqDbValue = 16'(v);
    @(negedge clk);
    cqDbWr = 1'b0;
    err = dbErr;
  endtask

  task automatic takeCpl(bit doRing);
    logic [127:0] w;
    int slot = slotOf(CQB) + hostCqRd;
    int waited = 0;
    bit e;
    while (mem[slot][112] !== expPhase && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    w = mem[slot];
    check(waited < 3000, "R2", "completion arrives", 64'(waited), 64'(0));
    check(w[111:96] == sqCid[hostCplSq] && w[95:80] == QID, "R5", "cid and queue id",
          64'(w[111:80]), 64'({sqCid[hostCplSq], QID}));
    check(w[79:64] == 16'((hostCplSq + 1) % SQD), "R5", "submission head",
          64'(w[79:64]), 64'((hostCplSq + 1) % SQD));
    check(w[112] == expPhase, "R6", "phase bit", 64'(w[112]), 64'(expPhase));
    check(w[127:113] == {14'b0, sqOp[hostCplSq][7]} && w[31:0] == sqRes[hostCplSq] &&
          w[63:32] == '0, "R10", "status and result",
          64'({w[127:113], w[31:0]}), 64'({14'b0, sqOp[hostCplSq][7], sqRes[hostCplSq]}));
    hostCplSq = (hostCplSq + 1) % SQD;
    hostCqRd  = (hostCqRd + 1) % CQD;
    if (hostCqRd == 0) expPhase = ~expPhase;
    if (doRing) ringCq(hostCqRd, e);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  initial begin
    bit e;
    int r, w0, n, unacked;
    bit doRing;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(irq == 1'b0, "R9", "irq after reset", 64'(irq), 64'(0));
    check(memReq == 1'b0 && dbErr == 1'b0, "R1", "idle after reset",
          64'({memReq, dbErr}), 64'(0));

    // R1: entries written without a doorbell are not fetched
    putCmd(8'h02, 16'h0011);
    putCmd(8'h81, 16'h0022);
    r = readCnt;
    repeat (40) @(negedge clk);
    check(readCnt == r, "R1", "no fetch before doorbell", 64'(readCnt), 64'(r));
    ringSq(hostSqTail, e);
    check(e == 1'b0, "R8", "valid doorbell raises no error", 64'(e), 64'(0));
    takeCpl(1'b0);
    takeCpl(1'b0);
    @(negedge clk);
    check(irq == 1'b1, "R9", "irq held while unconsumed", 64'(irq), 64'(1));
    ringCq(hostCqRd, e);
    check(irq == 1'b0, "R9", "irq drops when head catches up", 64'(irq), 64'(0));

    // R7: five commands in one doorbell, completion ring holds three
    for (int k = 0; k < 5; k++) putCmd(8'($urandom), 16'($urandom));
    w0 = wrCnt;
    ringSq(hostSqTail, e);
    repeat (300) @(negedge clk);
    check(wrCnt - w0 == CQD - 1, "R7", "posting stalls when full", 64'(wrCnt - w0), 64'(CQD - 1));
    check(irq == 1'b1, "R9", "irq during stall", 64'(irq), 64'(1));
    takeCpl(1'b0);
    takeCpl(1'b0);
    takeCpl(1'b1);
    takeCpl(1'b0);
    takeCpl(1'b1);
    @(negedge clk);
    check(irq == 1'b0, "R7", "stalled entries posted and freed", 64'(irq), 64'(0));

    // R8: out-of-range doorbells are dropped
    r = readCnt;
    ringSq(SQD, e);
    check(e == 1'b1, "R8", "error on tail == depth", 64'(e), 64'(1));
    ringSq(16'hFFFF, e);
    check(e == 1'b1, "R8", "error on tail 0xFFFF", 64'(e), 64'(1));
    repeat (40) @(negedge clk);
    check(readCnt == r, "R8", "bad tail starts no fetch", 64'(readCnt), 64'(r));
    ringCq(CQD + 1, e);
    check(e == 1'b1, "R8", "error on bad head", 64'(e), 64'(1));
    @(negedge clk);
    check(irq == 1'b0 && dbErr == 1'b0, "R8", "bad head ignored, error pulse ends",
          64'({irq, dbErr}), 64'(0));

    // R2: random batches with random consumption
    for (int it = 0; it < 25; it++) begin
      n = 1 + int'($urandom % (SQD - 1));
      for (int k = 0; k < n; k++) putCmd(8'($urandom), 16'($urandom));
      ringSq(hostSqTail, e);
      unacked = 0;
      for (int k = 0; k < n; k++) begin
        doRing = (k == n - 1) || (unacked + 1 == CQD - 1) || ($urandom % 2 == 0);
        takeCpl(doRing);
        unacked = doRing ? 0 : unacked + 1;
      end
    end
    repeat (10) @(negedge clk);
    check(readCnt == 4 * totalCmds, "R2", "every covered entry fetched once",
          64'(readCnt), 64'(4 * totalCmds));
    check(fetchAddrBad == 0, "R3", "command fetch addresses", 64'(fetchAddrBad), 64'(0));
    check(cplAddrBad == 0, "R3", "completion write addresses", 64'(cplAddrBad), 64'(0));
    check(beatOrderBad == 0, "R4", "four beats before each post", 64'(beatOrderBad), 64'(0));
    check(irqOrderBad == 0, "R4", "irq rises after write ack", 64'(irqOrderBad), 64'(0));
    summary();
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule